// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block stores the configuration state for a set of memory protection entries. Each entry owns an 8-bit configuration byte and an address register. The configuration byte holds read, write and execute permission bits, a two-bit match-mode field and a lock bit. Machine-level software reaches the state through a small CSR port. Configuration bytes are packed several to a CSR word. Address registers are reached one per CSR index in a separate bank. The complete state is also driven out in parallel, so a neighbouring range decoder can consume it.

Writes honour per-entry lock rules. An entry is frozen when its own lock bit is set. It is also frozen when the entry directly above it is locked and uses top-of-range matching, because that entry's range is bounded by this entry's address. The lock test is done separately for each byte of a packed write. Writes to entries that do not exist are dropped, and reads of them return zero. For every entry whose write is accepted, a one-cycle strobe tells the range decoder to refresh that entry.

Top module: `pmp_entry_regfile`

## Requirements
- R1: After reset, every configuration byte, every address register, the update strobes and the read data are all zero.
- R2: When the configuration bank is selected (`csr_sel_addr`=0), byte k (bits 8k+7:8k) of CSR word r is written to entry r*(XLEN/8)+k. The new byte appears on `cfg_bytes[8e+7:8e]` one cycle after the write.
- R3: A write to address-bank index i (`csr_sel_addr`=1) stores the low ADDR_W bits of the write data into entry i. The new value appears on `addr_regs` one cycle after the write.
- R4: If bit 7 (lock) of an entry's configuration byte is set, writes to that entry's configuration byte and to its address register are ignored until reset.
- R5: Entry i is also treated as locked when entry i+1 has bit 7 set and its match field, bits 4:3, equals 01 (top-of-range). A locked entry i+1 in mode 10 or 11 does not lock entry i.
- R6: The highest entry is governed only by its own lock bit.
- R7: In a packed configuration write, each byte is checked against its own entry's lock state, which is evaluated before the write. Unlocked bytes are updated and locked bytes are kept.
- R8: With XLEN=64, writes to odd configuration CSR indices are ignored, and reads of those indices return zero.
- R9: Writes to an entry number at or beyond NUM_ENTRIES are ignored, whether through either bank. Reads of such entries return zero: a whole word in the address bank, and the corresponding byte lanes in the configuration bank.
- R10: A read with `csr_re` high loads `csr_rdata` on the next clock edge with the selected value, zero-extended for addresses. `csr_rdata` holds its value while `csr_re` is low.
- R11: `entry_upd[e]` is high for exactly the cycle in which entry e's newly accepted value first appears. It stays low for ignored writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write enable |
| csr_re | input | 1 | CSR read enable |
| csr_sel_addr | input | 1 | Bank select: 0 configuration words, 1 address registers |
| csr_idx | input | IDX_W | CSR index within the selected bank |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Registered read data |
| cfg_bytes | output | NUM_ENTRIES*8 | All configuration bytes, entry e at bits 8e+7:8e |
| addr_regs | output | NUM_ENTRIES*ADDR_W | All address registers, entry e at slice e |
| entry_upd | output | NUM_ENTRIES | Per-entry strobe for an accepted write |

## Verification
On every cycle, the assertions check four things: a locked entry keeps both registers unchanged, a set lock bit never clears, an update strobe always follows a write request, and read data stays stable while no read is requested. They also check that address-bank writes and odd configuration words under a 64-bit width never reach a configuration byte. Other behaviour needs the bench's scenarios to show it. These cover the lock-through-neighbour relation with top-of-range against the other modes, the highest entry, a packed write that mixes locked and unlocked bytes, the byte-to-entry mapping, and zero reads beyond the populated entries.

// File: rtl/pmp_regfile_pkg.sv
package pmp_regfile_pkg;

   // configuration byte layout used by the lock logic
   localparam int CFG_BITS = 8;
   localparam int LOCK_BIT = 7;
   localparam int MODE_LO  = 3;
   localparam int MODE_HI  = 4;

   typedef enum logic [1:0] {
      MATCH_OFF   = 2'd0,
      MATCH_TOR   = 2'd1,
      MATCH_NA4   = 2'd2,
      MATCH_NAPOT = 2'd3
   } match_mode_e;

   function automatic logic cfg_lock(input logic [CFG_BITS-1:0] c);
      return c[LOCK_BIT];
   endfunction

   function automatic match_mode_e cfg_mode(input logic [CFG_BITS-1:0] c);
      return match_mode_e'(c[MODE_HI:MODE_LO]);
   endfunction

endpackage

// File: rtl/pmp_lock_eval.sv
module pmp_lock_eval
   import pmp_regfile_pkg::*;
#(
   parameter int NUM_ENTRIES = 24
) (
   input  logic [NUM_ENTRIES*CFG_BITS-1:0] cfg_flat,
   output logic [NUM_ENTRIES-1:0]          locked
);

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic [CFG_BITS-1:0] own;
      assign own = cfg_flat[e*CFG_BITS +: CFG_BITS];
      if (e == NUM_ENTRIES - 1) begin : g_top
         // no neighbour above the last entry
         assign locked[e] = cfg_lock(own);
      end else begin : g_mid
         logic [CFG_BITS-1:0] nxt;
         assign nxt       = cfg_flat[(e+1)*CFG_BITS +: CFG_BITS];
         assign locked[e] = cfg_lock(own) |
                            (cfg_lock(nxt) & (cfg_mode(nxt) == MATCH_TOR));
      end
   end

endmodule

// File: rtl/pmp_wr_decode.sv
module pmp_wr_decode #(
   parameter int NUM_ENTRIES = 24,
   parameter int XLEN        = 64,
   parameter int IDX_W       = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic                   sel_addr,
   input  logic [IDX_W-1:0]       idx,
   output logic [NUM_ENTRIES-1:0] cfg_hit,
   output logic [NUM_ENTRIES-1:0] addr_hit
);

   localparam int BYTES_PER_WORD = XLEN / 8;
   localparam bit WIDE           = (XLEN == 64);

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      localparam int CSR_NUM = e / BYTES_PER_WORD;
      localparam bit REACH   = !(WIDE && ((CSR_NUM % 2) == 1));
      if (REACH) begin : g_reach
         assign cfg_hit[e] = we & ~sel_addr & (idx == IDX_W'(CSR_NUM));
      end else begin : g_skip
         assign cfg_hit[e] = 1'b0;
      end
      assign addr_hit[e] = we & sel_addr & (idx == IDX_W'(e));
   end

   // R8
   cfg_bank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (sel_addr || (WIDE && idx[0]))) |-> (cfg_hit == '0));

   // R9
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_addr && (int'(idx) >= NUM_ENTRIES)) |-> (addr_hit == '0));

endmodule

// File: rtl/pmp_entry.sv
module pmp_entry
   import pmp_regfile_pkg::*;
#(
   parameter int ADDR_W = 54
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wen,
   input  logic                addr_wen,
   input  logic                lock,
   input  logic [CFG_BITS-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0]   addr_wdata,
   output logic [CFG_BITS-1:0] cfg_q,
   output logic [ADDR_W-1:0]   addr_q,
   output logic                upd
);

   logic cfg_take, addr_take;
   assign cfg_take  = cfg_wen  & ~lock;
   assign addr_take = addr_wen & ~lock;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         addr_q <= '0;
         upd    <= 1'b0;
      end else begin
         if (cfg_take)  cfg_q  <= cfg_wdata;
         if (addr_take) addr_q <= addr_wdata;
         upd <= cfg_take | addr_take;
      end
   end

   // R4
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(cfg_q) && $stable(addr_q)));

   // R4
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[LOCK_BIT] |=> cfg_q[LOCK_BIT]);

   // R11
   upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> $past(cfg_wen | addr_wen));

endmodule

// File: rtl/pmp_entry_regfile.sv
module pmp_entry_regfile
   import pmp_regfile_pkg::*;
#(
   parameter int NUM_ENTRIES = 24,
   parameter int XLEN        = 64,
   parameter int ADDR_W      = 54,
   parameter int IDX_W       = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            csr_we,
   input  logic                            csr_re,
   input  logic                            csr_sel_addr,
   input  logic [IDX_W-1:0]                csr_idx,
   input  logic [XLEN-1:0]                 csr_wdata,
   output logic [XLEN-1:0]                 csr_rdata,
   output logic [NUM_ENTRIES*CFG_BITS-1:0] cfg_bytes,
   output logic [NUM_ENTRIES*ADDR_W-1:0]   addr_regs,
   output logic [NUM_ENTRIES-1:0]          entry_upd
);

   localparam int BYTES_PER_WORD = XLEN / 8;
   localparam bit WIDE           = (XLEN == 64);

   // elaboration-time parameter checks
   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("XLEN must be 32 or 64");
   end
   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64) begin : g_bad_n
      $error("NUM_ENTRIES out of range 1..64");
   end
   if (ADDR_W < 1 || ADDR_W > XLEN) begin : g_bad_aw
      $error("ADDR_W must lie in 1..XLEN");
   end
   if ((NUM_ENTRIES - 1) >= (1 << IDX_W)) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_ENTRIES");
   end

   logic [NUM_ENTRIES-1:0] locked;
   logic [NUM_ENTRIES-1:0] cfg_hit;
   logic [NUM_ENTRIES-1:0] addr_hit;

   pmp_lock_eval #(.NUM_ENTRIES(NUM_ENTRIES)) u_lock (
      .cfg_flat (cfg_bytes),
      .locked   (locked)
   );

   pmp_wr_decode #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .XLEN        (XLEN),
      .IDX_W       (IDX_W)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (csr_we),
      .sel_addr (csr_sel_addr),
      .idx      (csr_idx),
      .cfg_hit  (cfg_hit),
      .addr_hit (addr_hit)
   );

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      localparam int LANE = e % BYTES_PER_WORD;
      pmp_entry #(.ADDR_W(ADDR_W)) u_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_wen    (cfg_hit[e]),
         .addr_wen   (addr_hit[e]),
         .lock       (locked[e]),
         .cfg_wdata  (csr_wdata[LANE*CFG_BITS +: CFG_BITS]),
         .addr_wdata (csr_wdata[ADDR_W-1:0]),
         .cfg_q      (cfg_bytes[e*CFG_BITS +: CFG_BITS]),
         .addr_q     (addr_regs[e*ADDR_W +: ADDR_W]),
         .upd        (entry_upd[e])
      );
   end

   // read selection
   logic [XLEN-1:0] rd_next;
   always_comb begin
      rd_next = '0;
      if (!csr_sel_addr) begin
         for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (!(WIDE && (((e / BYTES_PER_WORD) % 2) == 1)) &&
                (csr_idx == IDX_W'(e / BYTES_PER_WORD))) begin
               rd_next[(e % BYTES_PER_WORD)*CFG_BITS +: CFG_BITS] =
                  cfg_bytes[e*CFG_BITS +: CFG_BITS];
            end
         end
      end else begin
         for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (csr_idx == IDX_W'(e)) begin
               rd_next[ADDR_W-1:0] = addr_regs[e*ADDR_W +: ADDR_W];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      csr_rdata <= '0;
      else if (csr_re) csr_rdata <= rd_next;
   end

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_re |=> $stable(csr_rdata));

   // R11
   upd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|entry_upd) |-> $past(csr_we));

   // R8
   odd_word_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (WIDE && csr_re && !csr_sel_addr && csr_idx[0]) |=> (csr_rdata == '0));

endmodule

// File: tb/pmp_entry_regfile_test.sv
`timescale 1ns/1ps
module pmp_entry_regfile_test;

   localparam int N  = 24;
   localparam int XL = 64;
   localparam int AW = 54;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          csr_we, csr_re, csr_sel_addr;
   logic [IW-1:0] csr_idx;
   logic [XL-1:0] csr_wdata;
   logic [XL-1:0] csr_rdata;
   logic [N*8-1:0]  cfg_bytes;
   logic [N*AW-1:0] addr_regs;
   logic [N-1:0]    entry_upd;

   int checks = 0;
   int errors = 0;

   logic [7:0]    m_cfg  [N];
   logic [AW-1:0] m_addr [N];
   logic [N-1:0]  m_upd;

   always #2.5 clk = ~clk;

   pmp_entry_regfile #(.NUM_ENTRIES(N), .XLEN(XL), .ADDR_W(AW), .IDX_W(IW)) uut (
      .clk, .rst_n, .csr_we, .csr_re, .csr_sel_addr, .csr_idx,
      .csr_wdata, .csr_rdata, .cfg_bytes, .addr_regs, .entry_upd
   );

   function automatic logic m_locked(int e);
      if (m_cfg[e][7]) return 1'b1;
      if (e < N-1 && m_cfg[e+1][7] && m_cfg[e+1][4:3] == 2'b01) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [XL-1:0] m_read(bit sel, int idx);
      logic [XL-1:0] v = '0;
      if (sel) begin
         if (idx < N) v[AW-1:0] = m_addr[idx];
      end else if (idx % 2 == 0) begin
         for (int k = 0; k < 8; k++)
            if (idx*8 + k < N) v[k*8 +: 8] = m_cfg[idx*8 + k];
      end
      return v;
   endfunction

   task automatic chk(string tag, string what, logic [N*AW-1:0] act, logic [N*AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_state(string tag);
      logic [N*8-1:0]  ec;
      logic [N*AW-1:0] ea;
      for (int e = 0; e < N; e++) begin
         ec[e*8 +: 8]   = m_cfg[e];
         ea[e*AW +: AW] = m_addr[e];
      end
      chk(tag, "cfg_bytes", (N*AW)'(cfg_bytes), (N*AW)'(ec));
      chk(tag, "addr_regs", addr_regs, ea);
      chk(tag, "entry_upd", (N*AW)'(entry_upd), (N*AW)'(m_upd));
   endtask

   task automatic cfg_wr(int r, logic [XL-1:0] d, string tag);
      logic [N-1:0] lk;
      for (int e = 0; e < N; e++) lk[e] = m_locked(e);
      m_upd = '0;
      if (r % 2 == 0) begin
         for (int k = 0; k < 8; k++) begin
            int e = r*8 + k;
            if (e < N && !lk[e]) begin
               m_cfg[e] = d[k*8 +: 8];
               m_upd[e] = 1'b1;
            end
         end
      end
      csr_we = 1'b1; csr_sel_addr = 1'b0; csr_idx = r[IW-1:0]; csr_wdata = d;
      @(posedge clk); @(negedge clk);
      csr_we = 1'b0;
      check_state(tag);
   endtask

   task automatic addr_wr(int i, logic [XL-1:0] d, string tag);
      m_upd = '0;
      if (i < N && !m_locked(i)) begin
         m_addr[i] = d[AW-1:0];
         m_upd[i]  = 1'b1;
      end
      csr_we = 1'b1; csr_sel_addr = 1'b1; csr_idx = i[IW-1:0]; csr_wdata = d;
      @(posedge clk); @(negedge clk);
      csr_we = 1'b0;
      check_state(tag);
   endtask

   task automatic rd(bit sel, int idx, string tag);
      logic [XL-1:0] exp = m_read(sel, idx);
      csr_re = 1'b1; csr_sel_addr = sel; csr_idx = idx[IW-1:0];
      @(posedge clk); @(negedge clk);
      csr_re = 1'b0;
      m_upd = '0;
      chk(tag, "csr_rdata", (N*AW)'(csr_rdata), (N*AW)'(exp));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      csr_we = 1'b0; csr_re = 1'b0; csr_sel_addr = 1'b0; csr_idx = '0; csr_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
      m_upd = '0;
      check_state("R1");
      chk("R1", "csr_rdata", (N*AW)'(csr_rdata), '0);
   endtask

   function automatic logic [XL-1:0] rand_cfg_word();
      logic [XL-1:0] w;
      for (int k = 0; k < 8; k++) begin
         w[k*8 +: 8] = 8'($urandom);
         w[k*8 + 7]  = ($urandom % 24 == 0);
      end
      return w;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [XL-1:0] held;
      void'($urandom(32'd4242));
      do_reset();

      // mapping of bytes to entries, address storage, reads
      cfg_wr(0, 64'h1F0E_0D0C_0B0A_0908, "R2");
      addr_wr(3, '1, "R3");
      rd(1'b1, 3, "R10");
      held = csr_rdata;
      rd(1'b0, 0, "R2");
      rd(1'b1, 3, "R10");
      addr_wr(3, 64'h1234, "R11");
      chk("R10", "csr_rdata hold", (N*AW)'(csr_rdata), (N*AW)'(held));

      // own lock and per-byte packed write
      cfg_wr(0, 64'h0000_0000_0080_0000, "R4");
      addr_wr(2, 64'h55, "R4");
      cfg_wr(0, 64'h1111_1111_1111_1111, "R7");
      rd(1'b0, 0, "R7");

      // neighbour lock: TOR locks below, NAPOT does not
      cfg_wr(0, 64'h9811_8811_1111_1111, "R5");
      addr_wr(4, 64'hAAAA, "R5");
      addr_wr(5, 64'hBBBB, "R5");
      addr_wr(6, 64'hCCCC, "R5");
      addr_wr(7, 64'hDDDD, "R5");
      cfg_wr(0, 64'h0, "R7");

      // highest entry
      cfg_wr(2, 64'h0900_0000_0000_0000, "R6");
      addr_wr(23, 64'h777, "R6");
      cfg_wr(2, 64'h8800_0000_0000_0000, "R6");
      addr_wr(23, 64'h888, "R6");
      addr_wr(22, 64'h999, "R5");
      cfg_wr(2, 64'h0101_0101_0101_0101, "R6");

      // odd words and out-of-range entries
      cfg_wr(1, '1, "R8");
      rd(1'b0, 1, "R8");
      cfg_wr(3, '1, "R8");
      rd(1'b0, 3, "R8");
      addr_wr(27, '1, "R9");
      rd(1'b1, 27, "R9");
      cfg_wr(4, '1, "R9");
      rd(1'b0, 4, "R9");

      // random phase
      do_reset();
      for (int n = 0; n < 600; n++) begin
         case ($urandom % 4)
            0: cfg_wr($urandom % 5, rand_cfg_word(), "R7");
            1: addr_wr($urandom % 28, {$urandom, $urandom}, "R3");
            2: rd(1'b0, $urandom % 5, "R10");
            default: rd(1'b1, $urandom % 28, "R10");
         endcase
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule